// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one SDRAM read or write burst. A mode word (the same bit layout the memory's own mode register uses) sets the burst length, the ordering of addresses within the burst, the CAS latency and whether write bursts shrink to a single access. The block decodes that word every clock, registers the result and flags encodings it cannot honour.

A one-cycle start pulse carries a 9-bit starting column and a read/write qualifier. From the next clock edge the block issues one column per cycle on a valid strobe. For lengths 2, 4 and 8 the addresses stay inside the aligned block that holds the starting column, either counting up with wrap or stepping through the XOR of the start with a running index. A full-page burst walks the whole 512-column row, wrapping from 511 to 0, until a terminate input stops it. When a burst ends, a one-cycle done pulse follows the last address. A controller feeds the columns into its command path and uses done to move on.

Top module: `sdram_burst_seq`

## Requirements
- R1: The length field, mode bits [2:0], gives the burst length: 000 is 1, 001 is 2, 010 is 4, 011 is 8. After a start sampled at edge k, col_vld is high for exactly that many cycles starting at edge k. The first address equals start_col. done is high for one cycle at edge k+length, with col_vld low.
- R2: With mode bit [3] = 0 (sequential), address i of a burst of length L is (start_col & ~(L-1)) | ((start_col + i) & (L-1)). The upper bits stay fixed and the low bits wrap within the block.
- R3: With mode bit [3] = 1 (interleaved), address i is (start_col & ~(L-1)) | ((start_col ^ i) & (L-1)).
- R4: For length 1, mode bit [3] has no effect: one address, start_col, then done.
- R5: Length code 111 with mode bit [3] = 0 gives a full-page burst. Addresses increase by one modulo 512 and do not stop on their own. term sampled high at an edge during the burst ends it: col_vld is low and done is high after that same edge. term has no effect on bursts of length 1 to 8.
- R6: With mode bit [9] = 1, a start with is_write = 1 issues a single address. A start with is_write = 0 uses the programmed length.
- R7: mode_illegal is high, one edge after the mode word is applied, when any of these holds: the length code is 100, 101 or 110; the latency field [6:4] is neither 010 nor 011; the operating field [8:7] is not 00; or the word asks for a full page with interleaved order. A start while mode_illegal is high issues no address, and start_err pulses for one cycle.
- R8: cas_lat reads 2 for latency code 010 and 3 for 011, one edge after the mode word is applied. For any other code it reads 0.
- R9: A start sampled while col_vld is high is ignored. The running burst continues unchanged, and start_err is high for one cycle after that edge.
- R10: While rst_n is low, col_vld, done, start_err, mode_illegal and cas_lat are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| mode_word | input | 14 | Mode register image |
| start | input | 1 | One-cycle burst request |
| is_write | input | 1 | Request is a write burst |
| start_col | input | 9 | Starting column of the burst |
| term | input | 1 | Stops a full-page burst |
| col_out | output | 9 | Current column address |
| col_vld | output | 1 | col_out carries a burst address |
| done | output | 1 | One-cycle pulse after the last address |
| start_err | output | 1 | One-cycle pulse for a rejected start |
| mode_illegal | output | 1 | Registered mode word is unusable |
| cas_lat | output | 2 | Decoded CAS latency (0 when reserved) |

## Verification
A wrong block base or a wrong wrap shows up within one address as a column outside the aligned block or out of order, so the bench compares every issued column against an order it computes itself. A wrong burst counter shows up as col_vld staying high one cycle too long or dropping one cycle too early, with done moving by the same amount. A stale busy flag shows up at the very next start, which is either rejected or accepted in the wrong cycle. A decode error shows up one edge after the mode word changes, on mode_illegal or cas_lat.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int COL_W  = 9;
  localparam int MODE_W = 14;

  typedef struct packed {
    logic [COL_W-1:0] mask;      // burst length minus one
    logic             full;      // full-page burst
    logic             ilv;       // interleaved order
    logic             wr_single; // writes use one location
    logic [1:0]       cas;       // decoded latency, 0 when reserved
    logic             illegal;
  } cfg_t;
endpackage

// File: rtl/sbs_mode_decode.sv
module sbs_mode_decode
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  output cfg_t              cfg_q
);
  localparam int BT_BIT = 3;
  localparam int WB_BIT = 9;

  cfg_t cfg_d;
  logic cfg_en;

  always_comb begin
    cfg_d = '0;
    cfg_d.ilv       = mode_word[BT_BIT];
    cfg_d.wr_single = mode_word[WB_BIT];
    unique case (mode_word[2:0])
      3'b000, 3'b001, 3'b010, 3'b011:
        cfg_d.mask = COL_W'((1 << mode_word[1:0]) - 1);
      3'b111: begin
        cfg_d.mask = '1;
        cfg_d.full = 1'b1;
      end
      default: cfg_d.illegal = 1'b1;
    endcase
    unique case (mode_word[6:4])
      3'b010:  cfg_d.cas = 2'd2;
      3'b011:  cfg_d.cas = 2'd3;
      default: cfg_d.illegal = 1'b1;
    endcase
    if (mode_word[8:7] != 2'b00) cfg_d.illegal = 1'b1;
    if (cfg_d.full && cfg_d.ilv) cfg_d.illegal = 1'b1;
  end

  assign cfg_en = (cfg_d != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
  import sbs_pkg::*;
(
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv) low = base ^ idx;
    else     low = base + idx;
    col = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             term,
  input  logic [COL_W-1:0] next_col,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] idx_nxt,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             full_q,
  output logic [COL_W-1:0] col_q,
  output logic             act_q,
  output logic             done_q,
  output logic             err_q
);
  logic [COL_W-1:0] idx_q, idx_d, base_d, mask_d, col_d;
  logic             act_d, done_d, err_d, ilv_d, full_d;
  logic             single, last;

  assign single  = (cfg.mask == '0) || (is_write && cfg.wr_single);
  assign last    = full_q ? term : (idx_q == mask_q);
  assign idx_nxt = idx_q + 1'b1;

  always_comb begin
    idx_d  = idx_q;
    base_d = base_q;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    full_d = full_q;
    col_d  = col_q;
    act_d  = act_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (act_q) begin
      err_d = start;
      if (last) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_nxt;
        col_d = next_col;
      end
    end else if (start) begin
      if (cfg.illegal) begin
        err_d = 1'b1;
      end else begin
        act_d  = 1'b1;
        idx_d  = '0;
        col_d  = start_col;
        base_d = start_col;
        mask_d = single ? '0 : cfg.mask;
        ilv_d  = cfg.ilv && !single;
        full_d = cfg.full && !single;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      col_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      base_q <= base_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      full_q <= full_d;
      col_q  <= col_d;
      act_q  <= act_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              is_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              term,
  output logic [COL_W-1:0]  col_out,
  output logic              col_vld,
  output logic              done,
  output logic              start_err,
  output logic              mode_illegal,
  output logic [1:0]        cas_lat
);
  cfg_t             cfg;
  logic [COL_W-1:0] base, idx_nxt, burst_mask, next_col;
  logic             ilv, burst_full;

  sbs_mode_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_word (mode_word),
    .cfg_q     (cfg)
  );

  sbs_addr_gen u_gen (
    .base (base),
    .idx  (idx_nxt),
    .mask (burst_mask),
    .ilv  (ilv),
    .col  (next_col)
  );

  sbs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .start     (start),
    .is_write  (is_write),
    .start_col (start_col),
    .term      (term),
    .next_col  (next_col),
    .base_q    (base),
    .idx_nxt   (idx_nxt),
    .mask_q    (burst_mask),
    .ilv_q     (ilv),
    .full_q    (burst_full),
    .col_q     (col_out),
    .act_q     (col_vld),
    .done_q    (done),
    .err_q     (start_err)
  );

  assign mode_illegal = cfg.illegal;
  assign cas_lat      = cfg.cas;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             term,
  input logic [COL_W-1:0] col_out,
  input logic             col_vld,
  input logic             done,
  input logic             start_err,
  input logic             mode_illegal,
  input logic [COL_W-1:0] burst_mask,
  input logic             burst_full
);
  a_r1_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_vld && start && !mode_illegal) |=> (col_vld && col_out == $past(start_col)));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !col_vld);

  a_r2_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && $past(col_vld)) |-> (((col_out ^ $past(col_out)) & ~burst_mask) == '0));

  a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && $past(col_vld) && burst_full) |-> (col_out == COL_W'($past(col_out) + 1'b1)));

  a_r5_term_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && burst_full && term) |=> (done && !col_vld));

  a_r7_illegal_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_vld && start && mode_illegal) |=> (!col_vld && start_err));

  a_r9_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && start) |=> start_err);
endmodule

bind sdram_burst_seq sbs_checker u_sbs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .start_col    (start_col),
  .term         (term),
  .col_out      (col_out),
  .col_vld      (col_vld),
  .done         (done),
  .start_err    (start_err),
  .mode_illegal (mode_illegal),
  .burst_mask   (burst_mask),
  .burst_full   (burst_full)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] mode_word = '0;
  logic        start = 1'b0;
  logic        is_write = 1'b0;
  logic [8:0]  start_col = '0;
  logic        term = 1'b0;
  logic [8:0]  col_out;
  logic        col_vld, done, start_err, mode_illegal;
  logic [1:0]  cas_lat;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sdram_burst_seq u_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
    .is_write(is_write), .start_col(start_col), .term(term),
    .col_out(col_out), .col_vld(col_vld), .done(done),
    .start_err(start_err), .mode_illegal(mode_illegal), .cas_lat(cas_lat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] mk(input logic [2:0] bl, input logic bt,
                                     input logic [2:0] cl, input logic [1:0] op,
                                     input logic wb);
    return {4'b0, wb, op, cl, bt, bl};
  endfunction

  task automatic set_mode(input logic [13:0] m);
    mode_word = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] exp_col(input logic [8:0] s, input int i,
                                         input int len, input bit ilv);
    logic [8:0] m, lo;
    m  = 9'(len - 1);
    lo = ilv ? (s ^ 9'(i)) : 9'(s + 9'(i));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic run_burst(input logic [8:0] s, input bit wr, input int len,
                           input bit ilv, input string req);
    start = 1'b1; start_col = s; is_write = wr;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      check(col_vld === 1'b1, req, int'(col_vld), 1);
      check(col_out === exp_col(s, i, len, ilv), req, int'(col_out),
            int'(exp_col(s, i, len, ilv)));
      @(negedge clk);
    end
    check(col_vld === 1'b0 && done === 1'b1, req, int'({col_vld, done}), 1);
    @(negedge clk);
    check(done === 1'b0, {req, " done width"}, int'(done), 0);
  endtask

  task automatic t_reset;
    check(col_vld === 0 && done === 0 && start_err === 0, "R10 outputs", int'({col_vld, done, start_err}), 0);
    check(mode_illegal === 0 && cas_lat === 0, "R10 mode outs", int'({mode_illegal, cas_lat}), 0);
  endtask

  task automatic t_lengths;
    set_mode(mk(3'b001, 0, 3'b010, 2'b00, 0)); run_burst(9'h0AD, 0, 2, 0, "R1 len2");
    set_mode(mk(3'b010, 0, 3'b010, 2'b00, 0)); run_burst(9'h0AD, 0, 4, 0, "R1 len4");
    set_mode(mk(3'b011, 0, 3'b010, 2'b00, 0)); run_burst(9'h0AD, 0, 8, 0, "R2 seq len8");
    run_burst(9'h1F2, 0, 8, 0, "R2 seq len8 start2");
  endtask

  task automatic t_interleave;
    set_mode(mk(3'b011, 1, 3'b011, 2'b00, 0)); run_burst(9'h0AD, 0, 8, 1, "R3 ilv len8");
    set_mode(mk(3'b010, 1, 3'b011, 2'b00, 0)); run_burst(9'h037, 0, 4, 1, "R3 ilv len4");
    set_mode(mk(3'b001, 1, 3'b011, 2'b00, 0)); run_burst(9'h101, 0, 2, 1, "R3 ilv len2");
  endtask

  task automatic t_single;
    set_mode(mk(3'b000, 1, 3'b010, 2'b00, 0));
    check(mode_illegal === 0, "R4 bt ignored legal", int'(mode_illegal), 0);
    run_burst(9'h13B, 0, 1, 0, "R4 len1 bt1");
  endtask

  task automatic t_fullpage;
    set_mode(mk(3'b111, 0, 3'b010, 2'b00, 0));
    start = 1'b1; start_col = 9'h1FD; is_write = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(col_vld === 1 && col_out === 9'(9'h1FD + 9'(i)), "R5 page wrap",
            int'(col_out), int'(9'(9'h1FD + 9'(i))));
      @(negedge clk);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check(col_vld === 0 && done === 1, "R5 term ends", int'({col_vld, done}), 1);
    set_mode(mk(3'b011, 0, 3'b010, 2'b00, 0));
    start = 1'b1; start_col = 9'h044;
    @(negedge clk);
    start = 1'b0; term = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check(col_vld === 1 && col_out === exp_col(9'h044, i, 8, 0), "R5 term ignored len8",
            int'(col_out), int'(exp_col(9'h044, i, 8, 0)));
      @(negedge clk);
    end
    term = 1'b0;
    check(done === 1 && col_vld === 0, "R5 len8 natural end", int'({col_vld, done}), 1);
    @(negedge clk);
  endtask

  task automatic t_write_single;
    set_mode(mk(3'b011, 0, 3'b010, 2'b00, 1));
    run_burst(9'h0C3, 1, 1, 0, "R6 write single");
    run_burst(9'h0C3, 0, 8, 0, "R6 read full length");
  endtask

  task automatic t_illegal;
    set_mode(mk(3'b101, 0, 3'b010, 2'b00, 0));
    check(mode_illegal === 1, "R7 bl reserved", int'(mode_illegal), 1);
    start = 1'b1; start_col = 9'h010;
    @(negedge clk);
    start = 1'b0;
    check(col_vld === 0 && start_err === 1, "R7 start rejected", int'({col_vld, start_err}), 1);
    @(negedge clk);
    check(start_err === 0 && col_vld === 0, "R7 err one cycle", int'({col_vld, start_err}), 0);
    set_mode(mk(3'b111, 1, 3'b010, 2'b00, 0));
    check(mode_illegal === 1, "R7 page interleaved", int'(mode_illegal), 1);
    set_mode(mk(3'b011, 0, 3'b001, 2'b00, 0));
    check(mode_illegal === 1 && cas_lat === 0, "R7 R8 cl reserved", int'({mode_illegal, cas_lat}), 4);
    set_mode(mk(3'b011, 0, 3'b010, 2'b01, 0));
    check(mode_illegal === 1, "R7 op reserved", int'(mode_illegal), 1);
    set_mode(mk(3'b011, 0, 3'b011, 2'b00, 0));
    check(mode_illegal === 0 && cas_lat === 3, "R8 cl3", int'({mode_illegal, cas_lat}), 3);
    set_mode(mk(3'b011, 0, 3'b010, 2'b00, 0));
    check(cas_lat === 2, "R8 cl2", int'(cas_lat), 2);
  endtask

  task automatic t_busy;
    set_mode(mk(3'b011, 1, 3'b010, 2'b00, 0));
    start = 1'b1; start_col = 9'h0AD;
    @(negedge clk);
    start_col = 9'h000;
    @(negedge clk);
    start = 1'b0;
    check(start_err === 1, "R9 busy start err", int'(start_err), 1);
    check(col_out === exp_col(9'h0AD, 1, 8, 1), "R9 burst unchanged", int'(col_out),
          int'(exp_col(9'h0AD, 1, 8, 1)));
    for (int i = 2; i < 8; i++) begin
      @(negedge clk);
      check(col_vld === 1 && col_out === exp_col(9'h0AD, i, 8, 1), "R9 burst continues",
            int'(col_out), int'(exp_col(9'h0AD, i, 8, 1)));
    end
    @(negedge clk);
    check(done === 1 && start_err === 0, "R9 end", int'({done, start_err}), 2);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_lengths;
    t_interleave;
    t_single;
    t_fullpage;
    t_write_single;
    t_illegal;
    t_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule